// File: doc/BRIEF.md
# Access-Typed Register Field Cell

This block holds one field of a memory-mapped register. A single parameterised cell is configured to one of eight software access behaviours: plain read-write, read-only, write-only, clear-on-read, write-one-to-clear, write-one-to-set, write-zero-to-clear, and a write-one-to-clear variant whose software read returns zero. On the bus side it receives a write strobe with write data, and a read strobe that only the clear-on-read behaviour uses. On the hardware side it receives an update enable with update data. It returns the stored value to the peripheral logic (`q`), the value that the read-data multiplexer should show to software (`qs`), and a write-event pulse (`qe`).

When software and hardware both update the field in the same cycle, fixed rules decide the result. Software takes precedence for plain writes. For the set and clear behaviours, the software operation is applied on top of the value that hardware supplies. A second build option keeps no storage in the cell: the field then lives in the surrounding logic, and the cell only routes write data, the write strobe and the externally held value. In that option the write pulse appears in the same cycle as the write strobe, not one cycle later. Address decode is outside this block. All flops use a synchronous active-high reset.

Top module: `swfield_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the stored variant loads `RESET_VAL` into `q` and drives `qe` low after that edge.
- R2: Plain read-write (ACC_RW): a software write loads `sw_wd` even when `hw_de` is also high. Otherwise `hw_de` loads `hw_d`, and with neither strobe `q` holds.
- R3: Read-only (ACC_RO): `sw_we`, `sw_wd` and `sw_re` have no effect on `q`. `hw_de` loads `hw_d`.
- R4: Write-only (ACC_WO): a software write loads `sw_wd`, `hw_de` has no effect on `q`, and `qs` is always zero.
- R5: Clear-on-read (ACC_RC): a cycle with `sw_re` high leaves `q` at zero after the edge, even if `hw_de` is high in that cycle. Without `sw_re`, `hw_de` loads `hw_d`. `sw_we` is ignored.
- R6: Write-one-to-clear (ACC_W1C): the next value is the hardware-updated value (`hw_d` when `hw_de` is high, else `q`), with every bit cleared where a software write carries a 1 in `sw_wd`.
- R7: Write-one-to-clear with hardware holding a bit's `hw_d` high while software clears it: `q` shows that bit as 0 for exactly one cycle, then returns to 1.
- R8: Write-one-to-set (ACC_W1S): the next value is the hardware-updated value with every bit set where a software write carries a 1 in `sw_wd`.
- R9: Write-zero-to-clear (ACC_W0C): the next value is the hardware-updated value with every bit cleared where a software write carries a 0 in `sw_wd`.
- R10: Read-zero write-one-to-clear (ACC_R0W1C): `q` updates exactly as in R6, and `qs` is always zero.
- R11: For ACC_RW, ACC_RO, ACC_RC, ACC_W1C, ACC_W1S and ACC_W0C in the stored variant, `qs` equals `q`.
- R12: In the stored variant, `qe` is high in exactly the cycle after a cycle with `sw_we` high, which is the same edge at which `q` takes the written value.
- R13: External variant (`EXTERNAL=1`): `q` equals `sw_wd`, `qe` equals `sw_we`, and `qs` equals `hw_d`, all combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_we | input | 1 | Software write strobe from the bus decode |
| sw_wd | input | WIDTH | Software write data |
| sw_re | input | 1 | Software read strobe (used by clear-on-read) |
| hw_de | input | 1 | Hardware update enable |
| hw_d | input | WIDTH | Hardware update data, or the externally held value in the external variant |
| q | output | WIDTH | Field value presented to the peripheral logic |
| qs | output | WIDTH | Field value for the software read-data multiplexer |
| qe | output | 1 | Software write event pulse |

## Verification
The assertions assume that the strobes are clean single-bit values sampled at the rising edge. They also assume that reset is held high for the first clock edge, so no property is judged against flop contents from before reset. The bench changes inputs only one time unit after a rising edge and holds them for a full cycle. It drives the same stimulus into one instance of every access type at once, including cycles where the software write, the read strobe and the hardware update are all active together. The precedence rules are therefore exercised inside those assumptions.

// File: rtl/swfield_pkg.sv
package swfield_pkg;

  typedef enum logic [2:0] {
    ACC_RW    = 3'd0,
    ACC_RO    = 3'd1,
    ACC_WO    = 3'd2,
    ACC_RC    = 3'd3,
    ACC_W1C   = 3'd4,
    ACC_W1S   = 3'd5,
    ACC_W0C   = 3'd6,
    ACC_R0W1C = 3'd7
  } acc_e;

  // True when software reads see the stored value.
  function automatic logic sw_readable(acc_e acc);
    return !(acc == ACC_WO || acc == ACC_R0W1C);
  endfunction

endpackage

// File: rtl/swfield_next.sv
module swfield_next #(
  parameter int               WIDTH = 8,
  parameter swfield_pkg::acc_e ACC  = swfield_pkg::ACC_RW
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             sw_we,
  input  logic [WIDTH-1:0] sw_wd,
  input  logic             sw_re,
  input  logic             hw_de,
  input  logic [WIDTH-1:0] hw_d,
  output logic [WIDTH-1:0] nxt
);
  import swfield_pkg::*;

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] merged;
  logic [WIDTH-1:0] clr_mask;
  logic [WIDTH-1:0] set_mask;

  assign merged = hw_de ? hw_d : cur;

  always_comb begin
    clr_mask = ALL_ONES;
    set_mask = '0;
    nxt      = cur;
    case (ACC)
      ACC_RW:  nxt = sw_we ? sw_wd : merged;
      ACC_RO:  nxt = merged;
      ACC_WO:  nxt = sw_we ? sw_wd : cur;
      ACC_RC: begin
        if (sw_re) clr_mask = '0;
        nxt = merged & clr_mask;
      end
      ACC_W1C, ACC_R0W1C: begin
        if (sw_we) clr_mask = ~sw_wd;
        nxt = merged & clr_mask;
      end
      ACC_W1S: begin
        if (sw_we) set_mask = sw_wd;
        nxt = merged | set_mask;
      end
      ACC_W0C: begin
        if (sw_we) clr_mask = sw_wd;
        nxt = merged & clr_mask;
      end
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/swfield_store.sv
module swfield_store #(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] nxt,
  input  logic             sw_we,
  output logic [WIDTH-1:0] q,
  output logic             qe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q  <= RESET_VAL;
      qe <= 1'b0;
    end else begin
      q  <= nxt;
      qe <= sw_we;
    end
  end

endmodule

// File: rtl/swfield_ext.sv
module swfield_ext #(
  parameter int WIDTH = 8
) (
  input  logic             sw_we,
  input  logic [WIDTH-1:0] sw_wd,
  input  logic [WIDTH-1:0] hw_d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] qs,
  output logic             qe
);

  assign q  = sw_wd;
  assign qe = sw_we;
  assign qs = hw_d;

endmodule

// File: rtl/swfield_reg.sv
module swfield_reg #(
  parameter int                WIDTH     = 8,
  parameter logic [WIDTH-1:0]  RESET_VAL = '0,
  parameter swfield_pkg::acc_e ACC       = swfield_pkg::ACC_RW,
  parameter bit                EXTERNAL  = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_we,
  input  logic [WIDTH-1:0] sw_wd,
  input  logic             sw_re,
  input  logic             hw_de,
  input  logic [WIDTH-1:0] hw_d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] qs,
  output logic             qe
);
  import swfield_pkg::*;

  localparam bit READABLE = sw_readable(ACC);

  generate
    if (EXTERNAL) begin : g_ext
      logic unused_in;
      assign unused_in = ^{clk, rst, sw_re, hw_de};

      swfield_ext #(.WIDTH(WIDTH)) u_ext (
        .sw_we (sw_we),
        .sw_wd (sw_wd),
        .hw_d  (hw_d),
        .q     (q),
        .qs    (qs),
        .qe    (qe)
      );
    end else begin : g_store
      logic [WIDTH-1:0] nxt;
      logic [WIDTH-1:0] q_int;

      swfield_next #(.WIDTH(WIDTH), .ACC(ACC)) u_next (
        .cur   (q_int),
        .sw_we (sw_we),
        .sw_wd (sw_wd),
        .sw_re (sw_re),
        .hw_de (hw_de),
        .hw_d  (hw_d),
        .nxt   (nxt)
      );

      swfield_store #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_store (
        .clk   (clk),
        .rst   (rst),
        .nxt   (nxt),
        .sw_we (sw_we),
        .q     (q_int),
        .qe    (qe)
      );

      assign q = q_int;

      if (READABLE) begin : g_rd
        assign qs = q_int;
      end else begin : g_nord
        assign qs = '0;
      end
    end
  endgenerate

endmodule

// File: rtl/swfield_chk.sv
module swfield_chk #(
  parameter int                WIDTH     = 8,
  parameter logic [WIDTH-1:0]  RESET_VAL = '0,
  parameter swfield_pkg::acc_e ACC       = swfield_pkg::ACC_RW,
  parameter bit                EXTERNAL  = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             sw_we,
  input logic [WIDTH-1:0] sw_wd,
  input logic             sw_re,
  input logic             hw_de,
  input logic [WIDTH-1:0] hw_d,
  input logic [WIDTH-1:0] q,
  input logic [WIDTH-1:0] qs,
  input logic             qe
);
  import swfield_pkg::*;

  generate
    if (EXTERNAL) begin : g_ext
      p_ext_pass_r13: assert property (@(posedge clk) disable iff (rst)
        (qe == sw_we) && (qs == hw_d) && (q == sw_wd));
    end else begin : g_st
      p_reset_load_r1: assert property (@(posedge clk)
        rst |=> (q == RESET_VAL) && !qe);
      p_qe_rise_r12: assert property (@(posedge clk) disable iff (rst)
        sw_we |=> qe);
      p_qe_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !sw_we |=> !qe);

      if (ACC == ACC_RW) begin : g_rw
        p_sw_wins_r2: assert property (@(posedge clk) disable iff (rst)
          sw_we |=> (q == $past(sw_wd)));
      end
      if (ACC == ACC_RO) begin : g_ro
        p_ro_hold_r3: assert property (@(posedge clk) disable iff (rst)
          !hw_de |=> $stable(q));
      end
      if (ACC == ACC_WO) begin : g_wo
        p_wo_hold_r4: assert property (@(posedge clk) disable iff (rst)
          !sw_we |=> $stable(q));
      end
      if (ACC == ACC_RC) begin : g_rc
        p_read_clear_r5: assert property (@(posedge clk) disable iff (rst)
          sw_re |=> (q == '0));
      end
      if (ACC == ACC_W1C || ACC == ACC_R0W1C) begin : g_w1c
        p_one_clears_r6: assert property (@(posedge clk) disable iff (rst)
          sw_we |=> ((q & $past(sw_wd)) == '0));
      end
      if (ACC == ACC_W1S) begin : g_w1s
        p_one_sets_r8: assert property (@(posedge clk) disable iff (rst)
          sw_we |=> ((q & $past(sw_wd)) == $past(sw_wd)));
      end
      if (ACC == ACC_W0C) begin : g_w0c
        p_zero_clears_r9: assert property (@(posedge clk) disable iff (rst)
          sw_we |=> ((q & ~$past(sw_wd)) == '0));
      end
      if (sw_readable(ACC)) begin : g_rd
        p_qs_mirror_r11: assert property (@(posedge clk) disable iff (rst)
          qs == q);
      end else begin : g_nord
        p_qs_zero_r10: assert property (@(posedge clk) disable iff (rst)
          qs == '0);
      end
    end
  endgenerate

endmodule

bind swfield_reg swfield_chk #(
  .WIDTH     (WIDTH),
  .RESET_VAL (RESET_VAL),
  .ACC       (ACC),
  .EXTERNAL  (EXTERNAL)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .sw_we (sw_we),
  .sw_wd (sw_wd),
  .sw_re (sw_re),
  .hw_de (hw_de),
  .hw_d  (hw_d),
  .q     (q),
  .qs    (qs),
  .qe    (qe)
);

// File: tb/test_swfield_reg.sv
module test_swfield_reg;
  import swfield_pkg::*;

  localparam int          PERIOD = 10;
  localparam int          W      = 8;
  localparam int          NINST  = 9;   // 8 stored access types + 1 external
  localparam logic [W-1:0] RV    = 8'hA5;

  typedef struct packed {
    logic         we;
    logic [W-1:0] wd;
    logic         re;
    logic         de;
    logic [W-1:0] d;
    logic [W-1:0] rw_q;   // expected q of the plain read-write field
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 8'h3C, 1'b0, 1'b1, 8'hF0, 8'h3C},
    '{1'b0, 8'h00, 1'b0, 1'b1, 8'h0F, 8'h0F},
    '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h0F},
    '{1'b1, 8'hFF, 1'b1, 1'b0, 8'h00, 8'hFF},
    '{1'b0, 8'h00, 1'b1, 1'b1, 8'h55, 8'h55},
    '{1'b1, 8'hAA, 1'b0, 1'b0, 8'h00, 8'hAA},
    '{1'b1, 8'h0F, 1'b0, 1'b1, 8'hFF, 8'h0F},
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 8'h0F},
    '{1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00},
    '{1'b0, 8'h00, 1'b0, 1'b1, 8'h81, 8'h81}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sw_we = 1'b0;
  logic [W-1:0] sw_wd = '0;
  logic         sw_re = 1'b0;
  logic         hw_de = 1'b0;
  logic [W-1:0] hw_d  = '0;

  logic [W-1:0] q_a  [NINST];
  logic [W-1:0] qs_a [NINST];
  logic         qe_a [NINST];

  logic [W-1:0] mdl [8];

  int n_checks = 0;
  int n_errs   = 0;

  always #(PERIOD/2) clk = ~clk;

  for (genvar gi = 0; gi < NINST; gi++) begin : g_dut
    swfield_reg #(
      .WIDTH     (W),
      .RESET_VAL (RV),
      .ACC       ((gi < 8) ? acc_e'(gi) : ACC_RW),
      .EXTERNAL  (gi == 8)
    ) i_swfield_reg (
      .clk   (clk),
      .rst   (rst),
      .sw_we (sw_we),
      .sw_wd (sw_wd),
      .sw_re (sw_re),
      .hw_de (hw_de),
      .hw_d  (hw_d),
      .q     (q_a[gi]),
      .qs    (qs_a[gi]),
      .qe    (qe_a[gi])
    );
  end

  function automatic string tag(int t);
    case (t)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R8";
      6: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Expected next value built from the requirement text.
  function automatic logic [W-1:0] expect_next(int t, logic [W-1:0] cur);
    logic [W-1:0] hwv;
    hwv = hw_de ? hw_d : cur;
    case (t)
      0: return sw_we ? sw_wd : hwv;
      1: return hwv;
      2: return sw_we ? sw_wd : cur;
      3: return sw_re ? '0 : hwv;
      5: return sw_we ? (hwv | sw_wd) : hwv;
      6: return sw_we ? (hwv & sw_wd) : hwv;
      default: return sw_we ? (hwv & ~sw_wd) : hwv;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_outputs(logic exp_qe);
    for (int t = 0; t < 8; t++) begin
      chk(tag(t), "q", q_a[t], mdl[t]);
      if (t == 2 || t == 7)
        chk(t == 2 ? "R4" : "R10", "qs zero", qs_a[t], '0);
      else
        chk("R11", "qs mirrors q", qs_a[t], mdl[t]);
      chk("R12", "qe", {7'd0, qe_a[t]}, {7'd0, exp_qe});
    end
  endtask

  // Apply one cycle of stimulus, then check after the edge.
  task automatic step(logic we, logic [W-1:0] wd, logic re, logic de, logic [W-1:0] d);
    logic [W-1:0] nx [8];
    sw_we = we; sw_wd = wd; sw_re = re; hw_de = de; hw_d = d;
    #1;
    chk("R13", "ext q", q_a[8], wd);
    chk("R13", "ext qs", qs_a[8], d);
    chk("R13", "ext qe", {7'd0, qe_a[8]}, {7'd0, we});
    for (int t = 0; t < 8; t++) nx[t] = expect_next(t, mdl[t]);
    @(posedge clk);
    #1;
    for (int t = 0; t < 8; t++) mdl[t] = nx[t];
    check_outputs(we);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sw_we = 1'b0; sw_re = 1'b0; hw_de = 1'b0; sw_wd = '0; hw_d = '0;
    repeat (2) @(posedge clk);
    #1;
    for (int t = 0; t < 8; t++) begin
      mdl[t] = RV;
      chk("R1", "reset q", q_a[t], RV);
      chk("R1", "reset qe", {7'd0, qe_a[t]}, 8'd0);
    end
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();

    // Table walk: shared stimulus, RW expectation from the table (R2).
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i].we, VEC[i].wd, VEC[i].re, VEC[i].de, VEC[i].d);
      chk("R2", "table rw q", q_a[0], VEC[i].rw_q);
    end

    // R1: reset in the middle of activity.
    step(1'b1, 8'h12, 1'b0, 1'b0, 8'h00);
    do_reset();
    step(1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
    chk("R12", "qe low after idle", {7'd0, qe_a[0]}, 8'd0);

    // R7: hardware keeps bit 0 high while software clears it.
    step(1'b0, 8'h00, 1'b0, 1'b1, 8'h01);
    chk("R7", "w1c set by hw", q_a[4], 8'h01);
    step(1'b1, 8'h01, 1'b0, 1'b1, 8'h01);
    chk("R7", "w1c dropped one cycle", q_a[4], 8'h00);
    chk("R10", "r0w1c dropped", q_a[7], 8'h00);
    step(1'b0, 8'h00, 1'b0, 1'b1, 8'h01);
    chk("R7", "w1c returns", q_a[4], 8'h01);

    // R5: read strobe wins over same-cycle hardware update, write ignored.
    step(1'b1, 8'hFF, 1'b1, 1'b1, 8'h7E);
    chk("R5", "rc clear wins", q_a[3], 8'h00);
    step(1'b1, 8'h33, 1'b0, 1'b0, 8'h00);
    chk("R5", "rc ignores write", q_a[3], 8'h00);

    // R3 / R4: ignored strobes leave q unchanged.
    step(1'b0, 8'h00, 1'b0, 1'b1, 8'hC3);
    chk("R3", "ro hw load", q_a[1], 8'hC3);
    step(1'b1, 8'h5A, 1'b1, 1'b0, 8'h00);
    chk("R3", "ro ignores write", q_a[1], 8'hC3);
    chk("R4", "wo write", q_a[2], 8'h5A);
    step(1'b0, 8'h00, 1'b0, 1'b1, 8'h99);
    chk("R4", "wo ignores hw", q_a[2], 8'h5A);

    // R8 / R9 on top of hardware data.
    step(1'b1, 8'h0C, 1'b0, 1'b1, 8'h30);
    chk("R8", "w1s over hw", q_a[5], 8'h3C);
    chk("R9", "w0c over hw", q_a[6], 8'h00);
    step(1'b1, 8'hF0, 1'b0, 1'b1, 8'hCC);
    chk("R9", "w0c keeps ones", q_a[6], 8'hC0);

    finish_run();
  end

endmodule